// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds writes to a small architectural register file that must land a fixed number of ticks after they are issued. Each write sits in a ring of slots and carries its own countdown. A write can replace a whole register or one half of it, or it can set or clear a single bit. On every tick the occupied slots count down. A slot whose count runs out applies its update to the register file at once.

Slots drain in any order, but they are freed only from the head of the ring. A slot that drains behind the head is marked done. It keeps its place until every slot ahead of it has been freed. At most one slot is freed per tick. The producer sees the occupancy, a full flag and a consistency flag, and it reads the register file through a combinational read port.

Top module: `dlq_update_queue`

## Requirements
- R1: After reset, count_o is 0, full_o and fatal_o are 0, and every register reads 0.
- R2: An entry enqueued with delay d≥1 is applied on the clock edge of its d-th tick. A tick that coincides with the enqueue cycle does not count, and cycles without tick_i do not count.
- R3: An enqueued delay of 0 behaves as a delay of 1.
- R4: A full write with enq_wide_i=1 replaces all 64 bits. With enq_wide_i=0 it replaces bits 31:0 and keeps bits 63:32.
- R5: In bit mode (enq_bit_mode_i=1), a nonzero value sets the addressed bit and a zero value clears it. No other bit changes. The position is enq_bit_pos_i[5:0] when enq_wide_i=1 and enq_bit_pos_i[4:0] when enq_wide_i=0.
- R6: When several entries drain on the same tick and target the same register, they are applied oldest first, so the youngest value is the one that remains.
- R7: Only the head slot is freed, at most one per tick, and freeing it decrements count_o. An entry that drains behind the head still counts toward count_o until it reaches the head.
- R8: A drained entry is never decremented or applied again.
- R9: When count_o equals SLOTS, full_o is 1. An enqueue in that state is dropped and is never applied.
- R10: An update whose destination is SLOTS-independent and at or above NREG changes no register.
- R11: fatal_o is 1 when the in and out pointers differ while the count is zero. In normal operation it stays 0.
- R12: The in and out pointers wrap modulo SLOTS, and the queue keeps working across the wrap.
- R13: The register file changes only on a clock edge where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_dest_i | input | 4 | Destination register index |
| enq_bit_mode_i | input | 1 | 1 selects a single-bit set or clear |
| enq_bit_pos_i | input | 6 | Bit position used in bit mode |
| enq_wide_i | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| enq_value_i | input | 64 | Write data, or the set/clear selector in bit mode |
| enq_delay_i | input | 8 | Countdown in ticks |
| tick_i | input | 1 | Advance all countdowns by one |
| rd_idx_i | input | 2 | Register read index |
| rd_data_o | output | 64 | Register read data |
| count_o | output | 3 | Occupied slots |
| full_o | output | 1 | Ring is full |
| fatal_o | output | 1 | Pointer and count mismatch |

## Verification
The bench drives entries that drain out of order behind a slow head, and checks that count_o stays put until the head drains and then steps down by one per tick. A design that freed slots out of order, or that re-applied done slots, would show either a wrong count or a stale value overwriting a newer one. Bit-mode sweeps cover all 64 positions, both for setting and for clearing. These sweeps expose a clear that uses the plain mask rather than its inverse, and they expose wrong position truncation on 32-bit accesses. The bench also checks four simultaneous drains to one register after the pointers have wrapped, a rejected enqueue while full, a delay of 0, and an enqueue on a tick cycle. These catch off-by-one countdowns and a wrong application order.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int DEST_W = 4;
  localparam int BIT_W  = 6;
  localparam int DLY_W  = 8;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              bit_mode;
    logic [BIT_W-1:0]  bit_pos;
    logic              wide;
    logic [DATA_W-1:0] value;
  } upd_t;

  function automatic logic [DATA_W-1:0] apply_upd(input logic [DATA_W-1:0] cur, input upd_t u);
    logic [BIT_W-1:0]  pos;
    logic [DATA_W-1:0] msk;
    pos = u.wide ? u.bit_pos : {1'b0, u.bit_pos[BIT_W-2:0]};
    msk = DATA_W'(1) << pos;
    if (u.bit_mode)  return (u.value != '0) ? (cur | msk) : (cur & ~msk);
    else if (u.wide) return u.value;
    else             return {cur[DATA_W-1:HALF_W], u.value[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/dlq_ring_ctrl.sv
module dlq_ring_ctrl #(
  parameter int SLOTS = 4,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] in_o,
  output logic [PTR_W-1:0] out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             fatal_o
);
  logic [PTR_W-1:0] in_q, out_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) in_q  <= (in_q  == PTR_W'(SLOTS - 1)) ? '0 : in_q  + 1'b1;
      if (pop_i)  out_q <= (out_q == PTR_W'(SLOTS - 1)) ? '0 : out_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign in_o    = in_q;
  assign out_o   = out_q;
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(SLOTS));
  assign fatal_o = (in_q != out_q) && (cnt_q == '0);
endmodule

// File: rtl/dlq_slot.sv
module dlq_slot
  import dlq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  upd_t             upd_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tick_i,
  input  logic             free_i,
  output logic             valid_o,
  output logic             done_o,
  output logic             fire_o,
  output upd_t             upd_o
);
  logic             valid_q, done_q;
  logic [DLY_W-1:0] cnt_q;
  upd_t             upd_q;
  logic             active;

  assign active = tick_i && valid_q && !done_q;
  assign fire_o = active && (cnt_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      upd_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= (delay_i == '0) ? DLY_W'(1) : delay_i;
      upd_q   <= upd_i;
    end else if (free_i) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == DLY_W'(1)) done_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/dlq_apply.sv
module dlq_apply
  import dlq_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int NREG  = 4,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic [DATA_W-1:0] regs_i [NREG],
  input  logic [SLOTS-1:0]  fire_i,
  input  upd_t              upd_i  [SLOTS],
  input  logic [PTR_W-1:0]  head_i,
  output logic [DATA_W-1:0] regs_o [NREG]
);
  // walk from the head so younger entries win on the same register
  always_comb begin
    regs_o = regs_i;
    for (int k = 0; k < SLOTS; k++) begin
      int idx;
      idx = int'(head_i) + k;
      if (idx >= SLOTS) idx = idx - SLOTS;
      if (fire_i[idx]) begin
        for (int r = 0; r < NREG; r++) begin
          if (upd_i[idx].dest == DEST_W'(r)) regs_o[r] = apply_upd(regs_o[r], upd_i[idx]);
        end
      end
    end
  end
endmodule

// File: rtl/dlq_update_queue.sv
module dlq_update_queue
  import dlq_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int NREG  = 4,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int RD_W  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [DEST_W-1:0] enq_dest_i,
  input  logic              enq_bit_mode_i,
  input  logic [BIT_W-1:0]  enq_bit_pos_i,
  input  logic              enq_wide_i,
  input  logic [DATA_W-1:0] enq_value_i,
  input  logic [DLY_W-1:0]  enq_delay_i,
  input  logic              tick_i,
  input  logic [RD_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              fatal_o
);
  logic [PTR_W-1:0]  in_ptr, out_ptr;
  logic              push, pop;
  logic [SLOTS-1:0]  valid, done, fire, load, free;
  upd_t              upd_q [SLOTS];
  upd_t              enq_upd;
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];

  assign enq_upd = '{dest: enq_dest_i, bit_mode: enq_bit_mode_i, bit_pos: enq_bit_pos_i,
                     wide: enq_wide_i, value: enq_value_i};
  assign push = enq_valid_i && !full_o;
  assign pop  = tick_i && valid[out_ptr] && (done[out_ptr] || fire[out_ptr]);

  dlq_ring_ctrl #(.SLOTS(SLOTS)) u_ring (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .in_o(in_ptr), .out_o(out_ptr),
    .count_o, .full_o, .fatal_o
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign load[s] = push && (in_ptr  == PTR_W'(s));
    assign free[s] = pop  && (out_ptr == PTR_W'(s));
    dlq_slot u_slot (
      .clk_i, .rst_ni, .load_i(load[s]), .upd_i(enq_upd), .delay_i(enq_delay_i),
      .tick_i, .free_i(free[s]), .valid_o(valid[s]), .done_o(done[s]),
      .fire_o(fire[s]), .upd_o(upd_q[s])
    );
  end

  dlq_apply #(.SLOTS(SLOTS), .NREG(NREG)) u_apply (
    .regs_i(regs_q), .fire_i(fire), .upd_i(upd_q), .head_i(out_ptr), .regs_o(regs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
    end else if (tick_i) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_idx_i == RD_W'(r)) rd_data_o = regs_q[r];
    end
  end
endmodule

// File: rtl/dlq_update_queue_chk.sv
module dlq_update_queue_chk #(
  parameter int SLOTS = 4,
  parameter int NREG  = 4,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int RD_W  = $clog2(NREG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             tick_i,
  input logic [RD_W-1:0]  rd_idx_i,
  input logic [63:0]      rd_data_o,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             fatal_o
);
  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(SLOTS));
  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !tick_i |=> full_o);
  p_no_fatal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fatal_o);
  p_retire_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !enq_valid_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));
  p_idle_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !enq_valid_i |=> $stable(count_o));
  p_quiet_regs_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(rd_idx_i) -> $stable(rd_data_o)));
endmodule

bind dlq_update_queue dlq_update_queue_chk #(.SLOTS(SLOTS), .NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enq_valid_i(enq_valid_i), .tick_i(tick_i),
  .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .count_o(count_o), .full_o(full_o),
  .fatal_o(fatal_o)
);

// File: tb/dlq_update_queue_bench.sv
module dlq_update_queue_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq_valid_i = 1'b0;
  logic [3:0]  enq_dest_i = '0;
  logic        enq_bit_mode_i = 1'b0;
  logic [5:0]  enq_bit_pos_i = '0;
  logic        enq_wide_i = 1'b0;
  logic [63:0] enq_value_i = '0;
  logic [7:0]  enq_delay_i = '0;
  logic        tick_i = 1'b0;
  logic [1:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic [2:0]  count_o;
  logic        full_o, fatal_o;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_reg [4];

  always #10 clk_i = ~clk_i;

  dlq_update_queue u_dlq_update_queue (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int r);
    rd_idx_i = 2'(r);
    #1;
    chk(req, rd_data_o, exp_reg[r]);
  endtask

  task automatic chk_all(input string req);
    for (int r = 0; r < 4; r++) chk_reg(req, r);
    chk({req, " fatal R11"}, 64'(fatal_o), 64'd0);
  endtask

  task automatic enq(input logic [3:0] d, input logic bm, input logic [5:0] bp, input logic w,
                     input logic [63:0] v, input logic [7:0] dl, input logic tk);
    enq_valid_i = 1'b1; enq_dest_i = d; enq_bit_mode_i = bm; enq_bit_pos_i = bp;
    enq_wide_i = w; enq_value_i = v; enq_delay_i = dl; tick_i = tk;
    @(negedge clk_i);
    enq_valid_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) exp_reg[r] = '0;
    idle(2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 count", 64'(count_o), 0);
    chk("R1 full", 64'(full_o), 0);
    chk_all("R1 regs");

    // R2 delay sweep, 64-bit writes to reg0
    for (int d = 1; d <= 6; d++) begin
      logic [63:0] v;
      v = 64'h0123_4567_89AB_CDEF ^ (64'(d) * 64'h1111_0000_1111);
      enq(4'd0, 1'b0, 6'd0, 1'b1, v, 8'(d), 1'b0);
      idle(2); // R13 non-tick cycles do not count
      chk_reg("R13 quiet", 0);
      ticks(d - 1);
      chk_reg("R2 before expiry", 0);
      ticks(1);
      exp_reg[0] = v;
      chk_reg("R2 at expiry", 0);
      chk("R2 count", 64'(count_o), 0);
    end

    // R2 enqueue on a tick cycle: that tick is not counted
    enq(4'd3, 1'b0, 6'd0, 1'b1, 64'h5555, 8'd2, 1'b1);
    ticks(1);
    chk_reg("R2 enq-tick not counted", 3);
    ticks(1);
    exp_reg[3] = 64'h5555;
    chk_reg("R2 enq-tick applied", 3);

    // R3 delay 0 acts as 1
    enq(4'd3, 1'b0, 6'd0, 1'b1, 64'h7777_0000_0000_0003, 8'd0, 1'b0);
    ticks(1);
    exp_reg[3] = 64'h7777_0000_0000_0003;
    chk_reg("R3 delay zero", 3);

    // R4 full and half writes
    enq(4'd1, 1'b0, 6'd0, 1'b1, '1, 8'd1, 1'b0);
    ticks(1);
    exp_reg[1] = '1;
    chk_reg("R4 wide write", 1);
    enq(4'd1, 1'b0, 6'd0, 1'b0, 64'hABCD_0000_1234_5678, 8'd1, 1'b0);
    ticks(1);
    exp_reg[1] = 64'hFFFF_FFFF_1234_5678;
    chk_reg("R4 narrow write keeps upper", 1);

    // R5 bit set sweep then clear sweep on reg2
    for (int b = 0; b < 64; b++) begin
      enq(4'd2, 1'b1, 6'(b), 1'b1, 64'h100, 8'd1, 1'b0);
      ticks(1);
      exp_reg[2] = exp_reg[2] | (64'd1 << b);
      chk_reg("R5 bit set", 2);
    end
    for (int b = 0; b < 64; b++) begin
      enq(4'd2, 1'b1, 6'(b), 1'b1, 64'd0, 8'd1, 1'b0);
      ticks(1);
      exp_reg[2] = exp_reg[2] & ~(64'd1 << b);
      chk_reg("R5 bit clear", 2);
    end
    enq(4'd2, 1'b1, 6'd37, 1'b0, 64'd5, 8'd1, 1'b0);
    ticks(1);
    exp_reg[2] = 64'h20;
    chk_reg("R5 narrow bit position", 2);

    // R10 out-of-range destination
    enq(4'd9, 1'b0, 6'd0, 1'b1, 64'hDEAD_BEEF, 8'd1, 1'b0);
    ticks(1);
    chk_all("R10 no register written");
    chk("R10 count", 64'(count_o), 0);

    // R7/R8 out-of-order drain behind a slow head
    enq(4'd0, 1'b0, 6'd0, 1'b1, 64'hAAAA, 8'd5, 1'b0);
    enq(4'd1, 1'b0, 6'd0, 1'b1, 64'h1111, 8'd1, 1'b0);
    ticks(1);
    exp_reg[1] = 64'h1111;
    chk_reg("R7 non-head drains", 1);
    chk("R7 non-head keeps slot", 64'(count_o), 2);
    enq(4'd1, 1'b0, 6'd0, 1'b1, 64'h2222, 8'd1, 1'b0);
    ticks(1);
    exp_reg[1] = 64'h2222;
    chk_reg("R8 newer value", 1);
    chk("R7 count 3", 64'(count_o), 3);
    ticks(2);
    chk_reg("R8 no reapply", 1);
    chk_reg("R2 head pending", 0);
    chk("R7 count held", 64'(count_o), 3);
    ticks(1);
    exp_reg[0] = 64'hAAAA;
    chk_reg("R2 head applied", 0);
    chk("R7 head retire", 64'(count_o), 2);
    ticks(1);
    chk("R7 one per tick a", 64'(count_o), 1);
    ticks(1);
    chk("R7 one per tick b", 64'(count_o), 0);
    chk_reg("R8 still newer", 1);

    // R9/R6/R12 fill after wrap, reject, simultaneous drain
    for (int i = 0; i < 4; i++) enq(4'd0, 1'b0, 6'd0, 1'b1, 64'hC000 + 64'(i), 8'd15, 1'b0);
    chk("R9 count full", 64'(count_o), 4);
    chk("R9 full flag", 64'(full_o), 1);
    enq(4'd3, 1'b0, 6'd0, 1'b1, 64'hBAD0_BAD0, 8'd1, 1'b0);
    chk("R9 reject count", 64'(count_o), 4);
    ticks(14);
    chk_reg("R12 pending after wrap", 0);
    ticks(1);
    exp_reg[0] = 64'hC003;
    chk_reg("R6 youngest wins", 0);
    chk("R7 retire after burst", 64'(count_o), 3);
    ticks(3);
    chk("R12 drained", 64'(count_o), 0);
    chk("R9 not full", 64'(full_o), 0);
    chk_all("R9 rejected never applied");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule